// File: doc/BRIEF.md
# Console Cartridge Bank Mapper

This block is the bank-switching logic of a cartridge for an 8-bit console. It watches CPU writes into the cartridge window and keeps one 8-bit bank register. From that register it drives the upper program ROM address lines, the bank lines of the character RAM and the A10 select of the console's nametable RAM. The program space has two windows. The lower 16 KB window shows the bank held in the register. The upper 16 KB window always shows the last bank. Both come from one OR per address line between CPU A14 and a register bit.

The block is built in one of two modes. In locked mode, any write into the cartridge window loads the register. A parameter can model the bus conflict, in which the ROM byte at the written address is ANDed with the CPU data. In flashable mode, writes to the lower half pulse the program ROM write-enable so the ROM can be reprogrammed, and only writes to the upper half load the register, with no conflict. Parameters also set the character RAM size (8, 16 or 32 KB) and the mirroring choice (vertical, horizontal or register-controlled one-screen).

Top module: `cart_mapper`

## Requirements
- R1: The register is 8 bits wide. Bit 7 is the one-screen page, bits 6:5 are the 8 KB character RAM bank and bits 4:0 are the 16 KB program bank. After reset the register holds zero.
- R2: Each bit i of `prg_hi` (ROM A14+i) equals register bit i ORed with `cpu_a14`. With A14 low the selected bank appears on `prg_hi`. With A14 high `prg_hi` is 31.
- R3: In locked mode, a cycle with `romsel_n` low and `cpu_rw` low loads the register whatever the level of `cpu_a14`. The new value is visible from the cycle after the write strobe.
- R4: In locked mode with bus conflicts enabled, the loaded value is `cpu_d & rom_q`. With bus conflicts disabled it is `cpu_d`.
- R5: In flashable mode, a write with `cpu_a14` high loads `cpu_d` unchanged, even when bus conflicts are enabled.
- R6: In flashable mode, a write with `cpu_a14` low drives `prg_we_n` low in that same cycle and leaves the register unchanged.
- R7: `prg_oe_n` is low exactly when `romsel_n` is low and `cpu_rw` is high. In locked mode `prg_we_n` stays high.
- R8: `chr_hi[0]` (CHR A13) is register bit 5 for 16 KB and 32 KB of character RAM, and 1 for 8 KB. `chr_hi[1]` (CHR A14) is register bit 6 for 32 KB only, and 1 otherwise.
- R9: `ciram_a10` follows `ppu_a10` under vertical mirroring, `ppu_a11` under horizontal mirroring and register bit 7 under one-screen mirroring.
- R10: A cycle with `romsel_n` high or `cpu_rw` high never changes the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per CPU bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| romsel_n | input | 1 | Low while the CPU addresses the cartridge window |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_d | input | 8 | CPU data bus |
| rom_q | input | 8 | Byte the ROM drives at the current address (used for the bus conflict) |
| ppu_a10 | input | 1 | Video address bit 10 |
| ppu_a11 | input | 1 | Video address bit 11 |
| prg_hi | output | 5 | Program ROM address lines A18..A14 |
| chr_hi | output | 2 | Character RAM address lines A14..A13 |
| ciram_a10 | output | 1 | Nametable RAM A10 |
| prg_we_n | output | 1 | Program ROM write-enable, active low |
| prg_oe_n | output | 1 | Program ROM output-enable, active low |

## Verification
The assertions assume that each clock edge is one complete bus cycle, with `romsel_n`, `cpu_rw`, `cpu_a14` and the data settled before the edge. They also assume a write and a read never share a cycle. The bench drives every input on the falling edge and holds it through the next rising edge, so each strobe is a clean one-cycle event. It steps three instances with different parameter sets through the same stimulus, so the locked, conflict-free and flashable paths all see identical bus cycles.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;

    localparam int unsigned PRG_BANK_W = 5;
    localparam int unsigned CHR_BANK_W = 2;
    localparam int unsigned REG_W      = 1 + CHR_BANK_W + PRG_BANK_W;

    localparam int unsigned MIR_VERTICAL   = 0;
    localparam int unsigned MIR_HORIZONTAL = 1;
    localparam int unsigned MIR_ONE_SCREEN = 2;

    typedef struct packed {
        logic                  page;
        logic [CHR_BANK_W-1:0] chr_bank;
        logic [PRG_BANK_W-1:0] prg_bank;
    } bank_fields_t;

endpackage

// File: rtl/cart_bus_decode.sv
module cart_bus_decode
    import cart_mapper_pkg::*;
#(
    parameter bit FLASHABLE    = 1'b0,
    parameter bit BUS_CONFLICT = 1'b1
) (
    input  logic             romsel_n,
    input  logic             cpu_rw,
    input  logic             cpu_a14,
    input  logic [REG_W-1:0] cpu_d,
    input  logic [REG_W-1:0] rom_q,
    output logic             reg_load,
    output logic [REG_W-1:0] reg_data,
    output logic             prg_we_n,
    output logic             prg_oe_n
);

    logic bus_write;
    logic bus_read;

    always_comb begin
        bus_write = !romsel_n && !cpu_rw;
        bus_read  = !romsel_n &&  cpu_rw;
        prg_oe_n  = !bus_read;
    end

    generate
        if (FLASHABLE) begin : g_flash
            // upper half clocks the register, lower half goes to the ROM
            always_comb begin
                reg_load = bus_write &&  cpu_a14;
                prg_we_n = !(bus_write && !cpu_a14);
                reg_data = cpu_d;
            end
        end else begin : g_locked
            always_comb begin
                reg_load = bus_write;
                prg_we_n = 1'b1;
            end
            if (BUS_CONFLICT) begin : g_conflict
                always_comb reg_data = cpu_d & rom_q;
            end else begin : g_clean
                always_comb reg_data = cpu_d;
            end
        end
    endgenerate

    // R7: ROM is never written and read in the same cycle
    always_comb begin
        a_r7_we_oe_exclusive: assert (!(!prg_we_n && !prg_oe_n));
    end

endmodule

// File: rtl/cart_bank_reg.sv
module cart_bank_reg
    import cart_mapper_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] din,
    output bank_fields_t     bank
);

    typedef struct packed {
        bank_fields_t bank;
    } reg_state_t;

    reg_state_t state_d;
    reg_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.bank = bank_fields_t'(din);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bank = state_q.bank;

    // R10: without a load strobe the register holds
    a_r10_hold_without_load: assert property (
        @(posedge clk) disable iff (!rst_n)
        !load |=> $stable(state_q)
    );

endmodule

// File: rtl/cart_addr_map.sv
module cart_addr_map
    import cart_mapper_pkg::*;
#(
    parameter int unsigned CHR_KB = 32,
    parameter int unsigned MIRROR = MIR_ONE_SCREEN
) (
    input  bank_fields_t          bank,
    input  logic                  cpu_a14,
    input  logic                  ppu_a10,
    input  logic                  ppu_a11,
    output logic [PRG_BANK_W-1:0] prg_hi,
    output logic [CHR_BANK_W-1:0] chr_hi,
    output logic                  ciram_a10
);

    localparam int unsigned CHR_BANKS_USED = (CHR_KB >= 32) ? 2 : (CHR_KB >= 16) ? 1 : 0;

    // every upper PRG line is forced high in the fixed window
    generate
        for (genvar i = 0; i < PRG_BANK_W; i++) begin : g_prg
            assign prg_hi[i] = bank.prg_bank[i] | cpu_a14;
        end
        for (genvar j = 0; j < CHR_BANK_W; j++) begin : g_chr
            if (j < CHR_BANKS_USED) begin : g_bank
                assign chr_hi[j] = bank.chr_bank[j];
            end else begin : g_tie
                assign chr_hi[j] = 1'b1;
            end
        end
        if (MIRROR == MIR_VERTICAL) begin : g_vert
            assign ciram_a10 = ppu_a10;
        end else if (MIRROR == MIR_HORIZONTAL) begin : g_horiz
            assign ciram_a10 = ppu_a11;
        end else begin : g_one
            assign ciram_a10 = bank.page;
        end
    endgenerate

endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import cart_mapper_pkg::*;
#(
    parameter bit          FLASHABLE    = 1'b0,
    parameter bit          BUS_CONFLICT = 1'b1,
    parameter int unsigned CHR_KB       = 32,
    parameter int unsigned MIRROR       = MIR_ONE_SCREEN
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  romsel_n,
    input  logic                  cpu_rw,
    input  logic                  cpu_a14,
    input  logic [REG_W-1:0]      cpu_d,
    input  logic [REG_W-1:0]      rom_q,
    input  logic                  ppu_a10,
    input  logic                  ppu_a11,
    output logic [PRG_BANK_W-1:0] prg_hi,
    output logic [CHR_BANK_W-1:0] chr_hi,
    output logic                  ciram_a10,
    output logic                  prg_we_n,
    output logic                  prg_oe_n
);

    logic             reg_load;
    logic [REG_W-1:0] reg_data;
    bank_fields_t     bank;

    cart_bus_decode #(
        .FLASHABLE    (FLASHABLE),
        .BUS_CONFLICT (BUS_CONFLICT)
    ) u_decode (
        .romsel_n (romsel_n),
        .cpu_rw   (cpu_rw),
        .cpu_a14  (cpu_a14),
        .cpu_d    (cpu_d),
        .rom_q    (rom_q),
        .reg_load (reg_load),
        .reg_data (reg_data),
        .prg_we_n (prg_we_n),
        .prg_oe_n (prg_oe_n)
    );

    cart_bank_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (reg_load),
        .din   (reg_data),
        .bank  (bank)
    );

    cart_addr_map #(
        .CHR_KB (CHR_KB),
        .MIRROR (MIRROR)
    ) u_map (
        .bank      (bank),
        .cpu_a14   (cpu_a14),
        .ppu_a10   (ppu_a10),
        .ppu_a11   (ppu_a11),
        .prg_hi    (prg_hi),
        .chr_hi    (chr_hi),
        .ciram_a10 (ciram_a10)
    );

    generate
        if (FLASHABLE) begin : g_chk_flash
            // R6: a lower-half write only reaches the ROM
            a_r6_lower_write_keeps_bank: assert property (
                @(posedge clk) disable iff (!rst_n)
                (!romsel_n && !cpu_rw && !cpu_a14) |=> $stable(bank)
            );
            // R5: an upper-half write loads the CPU byte as-is
            a_r5_upper_write_loads_data: assert property (
                @(posedge clk) disable iff (!rst_n)
                (!romsel_n && !cpu_rw && cpu_a14) |=> (bank == $past(cpu_d))
            );
        end else if (!BUS_CONFLICT) begin : g_chk_clean
            // R3: any write in the window loads the register
            a_r3_write_loads_data: assert property (
                @(posedge clk) disable iff (!rst_n)
                (!romsel_n && !cpu_rw) |=> (bank == $past(cpu_d))
            );
        end else begin : g_chk_conflict
            // R4: conflicting bus keeps only bits both sides drive high
            a_r4_conflict_and: assert property (
                @(posedge clk) disable iff (!rst_n)
                (!romsel_n && !cpu_rw) |=> (bank == ($past(cpu_d) & $past(rom_q)))
            );
        end
    endgenerate

    // R10: reads and idle cycles leave the bank untouched
    a_r10_no_write_no_change: assert property (
        @(posedge clk) disable iff (!rst_n)
        (romsel_n || cpu_rw) |=> $stable(bank)
    );

endmodule

// File: tb/cart_mapper_tb_top.sv
module cart_mapper_tb_top;
    import cart_mapper_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       romsel_n = 1'b1;
    logic       cpu_rw = 1'b1;
    logic       cpu_a14 = 1'b0;
    logic [7:0] cpu_d = '0;
    logic [7:0] rom_q = '1;
    logic       ppu_a10 = 1'b0;
    logic       ppu_a11 = 1'b0;

    logic [4:0] prg_i, prg_f, prg_h;
    logic [1:0] chr_i, chr_f, chr_h;
    logic       cir_i, cir_f, cir_h;
    logic       we_i, we_f, we_h;
    logic       oe_i, oe_f, oe_h;

    always #(CLK_PERIOD/2) clk = ~clk;

    // locked, bus conflict, 32 KB CHR, one-screen
    cart_mapper #(.FLASHABLE(1'b0), .BUS_CONFLICT(1'b1), .CHR_KB(32), .MIRROR(MIR_ONE_SCREEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .romsel_n(romsel_n), .cpu_rw(cpu_rw), .cpu_a14(cpu_a14),
        .cpu_d(cpu_d), .rom_q(rom_q), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
        .prg_hi(prg_i), .chr_hi(chr_i), .ciram_a10(cir_i), .prg_we_n(we_i), .prg_oe_n(oe_i));
    // flashable, 16 KB CHR, vertical (conflict parameter set but must be ignored)
    cart_mapper #(.FLASHABLE(1'b1), .BUS_CONFLICT(1'b1), .CHR_KB(16), .MIRROR(MIR_VERTICAL)) dut_f (
        .clk(clk), .rst_n(rst_n), .romsel_n(romsel_n), .cpu_rw(cpu_rw), .cpu_a14(cpu_a14),
        .cpu_d(cpu_d), .rom_q(rom_q), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
        .prg_hi(prg_f), .chr_hi(chr_f), .ciram_a10(cir_f), .prg_we_n(we_f), .prg_oe_n(oe_f));
    // locked, no conflict, 8 KB CHR, horizontal
    cart_mapper #(.FLASHABLE(1'b0), .BUS_CONFLICT(1'b0), .CHR_KB(8), .MIRROR(MIR_HORIZONTAL)) dut_h (
        .clk(clk), .rst_n(rst_n), .romsel_n(romsel_n), .cpu_rw(cpu_rw), .cpu_a14(cpu_a14),
        .cpu_d(cpu_d), .rom_q(rom_q), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
        .prg_hi(prg_h), .chr_hi(chr_h), .ciram_a10(cir_h), .prg_we_n(we_h), .prg_oe_n(oe_h));

    typedef struct {
        string       tag;
        logic [29:0] expv;
    } exp_item_t;

    exp_item_t  sb_q[$];
    int         checks = 0;
    int         failures = 0;
    logic [7:0] m_i = '0, m_f = '0, m_h = '0;

    function automatic logic [9:0] model_out(input logic [7:0] r, input bit flash,
                                             input int chrkb, input int mir);
        logic [4:0] p;
        logic [1:0] c;
        logic       n, we, oe;
        p  = r[4:0] | {5{cpu_a14}};
        c  = (chrkb == 32) ? r[6:5] : (chrkb == 16) ? {1'b1, r[5]} : 2'b11;
        n  = (mir == 0) ? ppu_a10 : (mir == 1) ? ppu_a11 : r[7];
        we = flash ? !(!romsel_n && !cpu_rw && !cpu_a14) : 1'b1;
        oe = !(!romsel_n && cpu_rw);
        return {p, c, n, we, oe};
    endfunction

    // driver: one bus cycle, expectation pushed for after the next rising edge
    task automatic bus_cycle(input string tag, input logic rs_n, input logic rw,
                             input logic a14, input logic [7:0] d, input logic [7:0] q,
                             input logic a10, input logic a11);
        exp_item_t it;
        @(negedge clk);
        romsel_n = rs_n; cpu_rw = rw; cpu_a14 = a14;
        cpu_d = d; rom_q = q; ppu_a10 = a10; ppu_a11 = a11;
        if (!rs_n && !rw) begin
            m_i = d & q;
            m_h = d;
            if (a14) m_f = d;
        end
        it.tag  = tag;
        it.expv = {model_out(m_i, 1'b0, 32, 2), model_out(m_f, 1'b1, 16, 0),
                   model_out(m_h, 1'b0, 8, 1)};
        sb_q.push_back(it);
    endtask

    // monitor: compare after each rising edge
    initial begin
        exp_item_t  it;
        logic [29:0] act;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it  = sb_q.pop_front();
                act = {prg_i, chr_i, cir_i, we_i, oe_i, prg_f, chr_f, cir_f, we_f, oe_f,
                       prg_h, chr_h, cir_h, we_h, oe_h};
                checks++;
                if (act !== it.expv) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.expv);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset value zero, seen in the lower window
        bus_cycle("R1", 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0);
        bus_cycle("R1", 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b0);

        // R2: every bank in both windows (upper-half write loads all three)
        for (int b = 0; b < 32; b++) begin
            bus_cycle("R2", 1'b0, 1'b0, 1'b1, 8'(b), 8'hFF, 1'b0, 1'b0);
            bus_cycle("R2", 1'b0, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0);
            bus_cycle("R2", 1'b0, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b0);
        end

        // R3 / R6: lower-half write loads the locked builds, strobes flash WE
        bus_cycle("R3", 1'b0, 1'b0, 1'b0, 8'h15, 8'hFF, 1'b0, 1'b0);
        bus_cycle("R6", 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0);
        bus_cycle("R6", 1'b0, 1'b0, 1'b0, 8'hEA, 8'hFF, 1'b1, 1'b1);
        bus_cycle("R6", 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b1, 1'b1);

        // R4 / R5: conflicting ROM byte
        bus_cycle("R4", 1'b0, 1'b0, 1'b1, 8'hF3, 8'h0F, 1'b0, 1'b0);
        bus_cycle("R5", 1'b1, 1'b1, 1'b0, 8'h00, 8'h0F, 1'b0, 1'b0);
        bus_cycle("R4", 1'b0, 1'b0, 1'b0, 8'hAA, 8'h3C, 1'b0, 1'b0);
        bus_cycle("R4", 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0);

        // R7: read strobe drives OE
        bus_cycle("R7", 1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 1'b0, 1'b0);
        bus_cycle("R7", 1'b0, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b0);

        // R8: every CHR bank value
        for (int c = 0; c < 4; c++) begin
            bus_cycle("R8", 1'b0, 1'b0, 1'b1, 8'(c << 5) | 8'h09, 8'hFF, 1'b0, 1'b0);
            bus_cycle("R8", 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0);
        end

        // R9: page bit and all video address combinations
        for (int pg = 0; pg < 2; pg++) begin
            bus_cycle("R9", 1'b0, 1'b0, 1'b1, 8'(pg << 7), 8'hFF, 1'b0, 1'b0);
            for (int v = 0; v < 4; v++) begin
                bus_cycle("R9", 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, v[0], v[1]);
            end
        end

        // R10: write with romsel high, and reads, change nothing
        bus_cycle("R10", 1'b0, 1'b0, 1'b1, 8'h47, 8'hFF, 1'b0, 1'b0);
        bus_cycle("R10", 1'b1, 1'b0, 1'b1, 8'hB8, 8'hFF, 1'b0, 1'b0);
        bus_cycle("R10", 1'b1, 1'b0, 1'b0, 8'hB8, 8'hFF, 1'b0, 1'b0);
        bus_cycle("R10", 1'b0, 1'b1, 1'b1, 8'hB8, 8'hFF, 1'b0, 1'b0);
        bus_cycle("R10", 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0);

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard actual=%0d expected=0", sb_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule